// File: doc/BRIEF.md
# Flash Command Sequencer with Access-Error Trapping

This block is the control front end for an on-chip flash array. Software starts an operation in three strictly ordered steps. First it writes to an address inside the array window, and the block captures that address and byte. Next it writes an operation code to the command register. Finally it writes 1 to the ready bit of the status register, which starts the operation. While the operation runs, the block drives the array's erase and program strobes and the enable for the high-voltage pump. A blank check does not use the strobes: the block reads every array location through a dedicated read port.

Any step taken out of order is trapped. So is any step taken before the clock divider has been written, and so is an unknown operation code. A trapped step sets a sticky access-error flag, drops any partly built sequence, and leaves the array untouched. A burst byte-program operation keeps the pump on from one byte to the next, as long as the bytes stay within one 64-byte row. This saves the pump ramp time for each byte of a streamed row.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the ready flag (`stat_bufempty`) is 1, the done flag is 1, the access-error flag is 0, blank-ok is 0, the pump is off and no strobe is active.
- R2: The register select is 0 for the divider, 1 for the command and 2 for status. A status write with bit 7 = 1, made after an array write and then a valid command write, starts the operation. From the next cycle the ready and done flags read 0. For erase and program operations both flags return to 1 exactly OP_CYCLES cycles after the start.
- R3: Byte program (code 0x20) pulses `fl_prog_stb` for one cycle, in the first busy cycle, with the captured address and byte on `fl_addr` and `fl_wdata`. The pump is on while the operation runs and is off from the cycle in which the ready flag returns.
- R4: Page erase (code 0x40) pulses `fl_erase_stb` with `fl_erase_all` = 0. `fl_addr` carries the captured address with its low 9 bits cleared, which selects the 512-byte page. Mass erase (code 0x41) pulses `fl_erase_stb` with `fl_erase_all` = 1.
- R5: Blank check (code 0x05) ignores the captured address and byte. It reads addresses 0 to 2^ADDR_W−1 in order, one per cycle, and then sets the ready and done flags. Blank-ok is 1 at that point only if every byte read was 0xFF.
- R6: An array write made before any write to the divider register sets the access-error flag and captures nothing.
- R7: An array write made while an operation runs sets the access-error flag. The running operation still completes on time with its original address and data.
- R8: Each of the following sets the access-error flag and discards the pending sequence: a command write with no captured address, a second command write, an unknown command code, and a start request with no command. A start request made while an operation runs has no effect.
- R9: A status write with bit 7 = 0 while a sequence is pending aborts it. It sets the access-error flag, and no strobe follows.
- R10: The access-error flag stays set until a status write with bit 5 = 1 clears it. While it is set, array writes, command writes and start requests have no effect.
- R11: With burst program (code 0x25) the pump stays on after each byte completes. It turns off when the next array write falls in a different 64-byte row, when a non-burst command is written, or when an access error occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 divider, 1 command, 2 status |
| reg_wdata | input | 8 | Register write data |
| arr_wr | input | 1 | Write into the array window (first step) |
| arr_addr | input | ADDR_W | Array address for the first step |
| arr_wdata | input | 8 | Array data for the first step |
| fl_rdata | input | 8 | Array read data at `fl_raddr` |
| stat_bufempty | output | 1 | Ready for a new sequence (no operation running) |
| stat_done | output | 1 | Last operation completed |
| stat_accerr | output | 1 | Sticky access-error flag |
| stat_blank_ok | output | 1 | Last blank check found the whole array erased |
| fl_addr | output | ADDR_W | Array address for strobes (page-aligned for erase) |
| fl_wdata | output | 8 | Byte to program |
| fl_prog_stb | output | 1 | One-cycle program strobe |
| fl_erase_stb | output | 1 | One-cycle erase strobe |
| fl_erase_all | output | 1 | Erase strobe targets the whole array |
| fl_raddr | output | ADDR_W | Blank-check read address |
| fl_pump_en | output | 1 | High-voltage pump enable |

## Verification
The bench runs the three-step sequence with program, page-erase, mass-erase, blank-check and burst codes. This shows that each code reaches the right strobe and address form, and that the page erase leaves neighbouring pages alone. It also tries each illegal ordering on its own: a write before the divider is set, an array write during an operation, a command with no address, a double command, an unknown code, a start with no command, and an abort. In each case an unchanged array and a set error flag tell a trapped sequence apart from one that ran. Burst bytes in the same row, in a new row, and followed by a plain program separate the cases in which the pump must stay on from those in which it must turn off.

// File: rtl/flc_pkg.sv
package flc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LATCHED,
        S_CMDED,
        S_BUSY,
        S_SCAN
    } seq_state_t;

    localparam logic [7:0] CMD_PROG       = 8'h20;
    localparam logic [7:0] CMD_BURST      = 8'h25;
    localparam logic [7:0] CMD_PAGE_ERASE = 8'h40;
    localparam logic [7:0] CMD_MASS_ERASE = 8'h41;
    localparam logic [7:0] CMD_BLANK      = 8'h05;

    localparam logic [1:0] SEL_DIV  = 2'd0;
    localparam logic [1:0] SEL_CMD  = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;

    localparam int STAT_GO_BIT  = 7;
    localparam int STAT_ERR_BIT = 5;

    typedef struct packed {
        logic divwr;
        logic latch;
        logic cmd;
        logic launch;
        logic err;
        logic errclr;
    } seq_ev_t;

    function automatic logic cmd_known(input logic [7:0] code);
        return (code == CMD_PROG) || (code == CMD_BURST) ||
               (code == CMD_PAGE_ERASE) || (code == CMD_MASS_ERASE) ||
               (code == CMD_BLANK);
    endfunction

endpackage

// File: rtl/flc_decode.sv
module flc_decode
    import flc_pkg::*;
(
    input  seq_state_t st,
    input  logic       div_set,
    input  logic       err_set,
    input  logic       reg_wr,
    input  logic [1:0] reg_sel,
    input  logic [7:0] reg_wdata,
    input  logic       arr_wr,
    output seq_ev_t    ev
);

    logic pending;
    logic running;

    assign pending = (st == S_LATCHED) || (st == S_CMDED);
    assign running = (st == S_BUSY) || (st == S_SCAN);

    always_comb begin
        ev = '0;
        if (reg_wr) begin
            case (reg_sel)
                SEL_DIV: ev.divwr = 1'b1;
                SEL_CMD: begin
                    if (!err_set) begin
                        if (st != S_LATCHED || !cmd_known(reg_wdata)) ev.err = 1'b1;
                        else                                          ev.cmd = 1'b1;
                    end
                end
                SEL_STAT: begin
                    ev.errclr = reg_wdata[STAT_ERR_BIT];
                    if (!err_set) begin
                        if (reg_wdata[STAT_GO_BIT]) begin
                            if (st == S_CMDED) ev.launch = 1'b1;
                            else if (!running) ev.err    = 1'b1;
                        end else if (pending) begin
                            ev.err = 1'b1;
                        end
                    end
                end
                default: ev = '0;
            endcase
        end else if (arr_wr && !err_set) begin
            if (!div_set || st != S_IDLE) ev.err   = 1'b1;
            else                          ev.latch = 1'b1;
        end
    end

endmodule

// File: rtl/flc_seq.sv
module flc_seq
    import flc_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int OP_CYCLES  = 8,
    parameter int PAGE_BYTES = 512,
    parameter int ROW_BYTES  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_ev_t           ev,
    input  logic [7:0]        cmd_code,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic [7:0]        arr_wdata,
    input  logic [7:0]        fl_rdata,
    output seq_state_t        st,
    output logic              div_set,
    output logic              err_set,
    output logic              bufempty,
    output logic              done,
    output logic              blank_ok,
    output logic              pump_en,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    output logic              prog_stb,
    output logic              erase_stb,
    output logic              erase_all,
    output logic [ADDR_W-1:0] fl_raddr
);

    localparam int OPC_W    = $clog2(OP_CYCLES + 1);
    localparam int CNT_W    = (ADDR_W > OPC_W) ? ADDR_W : OPC_W;
    localparam int PAGE_LSB = $clog2(PAGE_BYTES);
    localparam int ROW_LSB  = $clog2(ROW_BYTES);
    localparam int ROW_W    = ADDR_W - ROW_LSB;
    localparam logic [CNT_W-1:0] LAST_SCAN = CNT_W'((1 << ADDR_W) - 1);
    localparam logic [CNT_W-1:0] OP_LOAD   = CNT_W'(OP_CYCLES - 1);

    typedef struct packed {
        seq_state_t        st;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic [7:0]        cmd;
        logic [CNT_W-1:0]  cnt;
        logic              div_set;
        logic              err;
        logic              done;
        logic              blank_ok;
        logic              blank_fail;
        logic              hold;
        logic [ROW_W-1:0]  row;
        logic              prog_stb;
        logic              erase_stb;
        logic              erase_all;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;
    logic     is_erase;
    logic     byte_blank;

    assign is_erase   = (seq_q.cmd == CMD_PAGE_ERASE) || (seq_q.cmd == CMD_MASS_ERASE);
    assign byte_blank = (fl_rdata == 8'hFF);

    always_comb begin
        seq_d           = seq_q;
        seq_d.prog_stb  = 1'b0;
        seq_d.erase_stb = 1'b0;

        case (seq_q.st)
            S_BUSY: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st   = S_IDLE;
                    seq_d.done = 1'b1;
                    if (seq_q.cmd == CMD_BURST) begin
                        seq_d.hold = 1'b1;
                        seq_d.row  = seq_q.addr[ADDR_W-1:ROW_LSB];
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            S_SCAN: begin
                if (!byte_blank) seq_d.blank_fail = 1'b1;
                if (seq_q.cnt == LAST_SCAN) begin
                    seq_d.st       = S_IDLE;
                    seq_d.done     = 1'b1;
                    seq_d.blank_ok = !(seq_q.blank_fail || !byte_blank);
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: ;
        endcase

        if (ev.divwr)  seq_d.div_set = 1'b1;
        if (ev.errclr) seq_d.err     = 1'b0;

        if (ev.err) begin
            seq_d.err  = 1'b1;
            seq_d.hold = 1'b0;
            if (seq_q.st == S_LATCHED || seq_q.st == S_CMDED) seq_d.st = S_IDLE;
        end

        if (ev.latch) begin
            seq_d.st   = S_LATCHED;
            seq_d.addr = arr_addr;
            seq_d.data = arr_wdata;
            if (arr_addr[ADDR_W-1:ROW_LSB] != seq_q.row) seq_d.hold = 1'b0;
        end

        if (ev.cmd) begin
            seq_d.st  = S_CMDED;
            seq_d.cmd = cmd_code;
            if (cmd_code != CMD_BURST) seq_d.hold = 1'b0;
        end

        if (ev.launch) begin
            seq_d.done = 1'b0;
            if (seq_q.cmd == CMD_BLANK) begin
                seq_d.st         = S_SCAN;
                seq_d.cnt        = '0;
                seq_d.blank_fail = 1'b0;
                seq_d.blank_ok   = 1'b0;
            end else begin
                seq_d.st        = S_BUSY;
                seq_d.cnt       = OP_LOAD;
                seq_d.prog_stb  = (seq_q.cmd == CMD_PROG) || (seq_q.cmd == CMD_BURST);
                seq_d.erase_stb = is_erase;
                seq_d.erase_all = (seq_q.cmd == CMD_MASS_ERASE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.st   <= S_IDLE;
            seq_q.done <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign st        = seq_q.st;
    assign div_set   = seq_q.div_set;
    assign err_set   = seq_q.err;
    assign bufempty  = (seq_q.st != S_BUSY) && (seq_q.st != S_SCAN);
    assign done      = seq_q.done;
    assign blank_ok  = seq_q.blank_ok;
    assign pump_en   = (seq_q.st == S_BUSY) || seq_q.hold;
    assign fl_addr   = is_erase ? {seq_q.addr[ADDR_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}} : seq_q.addr;
    assign fl_wdata  = seq_q.data;
    assign prog_stb  = seq_q.prog_stb;
    assign erase_stb = seq_q.erase_stb;
    assign erase_all = seq_q.erase_all;
    assign fl_raddr  = seq_q.cnt[ADDR_W-1:0];

    // R3: strobes only while an erase/program operation runs, never two at once
    a_r3_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.prog_stb || seq_q.erase_stb) |-> seq_q.st == S_BUSY);
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seq_q.prog_stb, seq_q.erase_stb}));
    // R2: done rises only as a running operation ends
    a_r2_done_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.done) |-> ($past(seq_q.st) == S_BUSY || $past(seq_q.st) == S_SCAN));
    // R8: a trapped step leaves no pending sequence
    a_r8_err_discards: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.err) |-> (seq_q.st != S_LATCHED && seq_q.st != S_CMDED));
    // R11: pump hold comes only from a completed burst byte
    a_r11_hold_from_burst: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.hold) |-> ($past(seq_q.cmd) == CMD_BURST && $past(seq_q.st) == S_BUSY));
    // R10: while the error flag is set no new operation starts
    a_r10_no_start_in_err: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seq_q.err) && $past(seq_q.st) == S_IDLE) |-> seq_q.st != S_BUSY);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flc_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int OP_CYCLES  = 8,
    parameter int PAGE_BYTES = 512,
    parameter int ROW_BYTES  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic              arr_wr,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic [7:0]        arr_wdata,
    input  logic [7:0]        fl_rdata,
    output logic              stat_bufempty,
    output logic              stat_done,
    output logic              stat_accerr,
    output logic              stat_blank_ok,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    output logic              fl_prog_stb,
    output logic              fl_erase_stb,
    output logic              fl_erase_all,
    output logic [ADDR_W-1:0] fl_raddr,
    output logic              fl_pump_en
);

    seq_state_t st;
    seq_ev_t    ev;
    logic       div_set;

    flc_decode u_decode (
        .st        (st),
        .div_set   (div_set),
        .err_set   (stat_accerr),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .arr_wr    (arr_wr),
        .ev        (ev)
    );

    flc_seq #(
        .ADDR_W     (ADDR_W),
        .OP_CYCLES  (OP_CYCLES),
        .PAGE_BYTES (PAGE_BYTES),
        .ROW_BYTES  (ROW_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .cmd_code  (reg_wdata),
        .arr_addr  (arr_addr),
        .arr_wdata (arr_wdata),
        .fl_rdata  (fl_rdata),
        .st        (st),
        .div_set   (div_set),
        .err_set   (stat_accerr),
        .bufempty  (stat_bufempty),
        .done      (stat_done),
        .blank_ok  (stat_blank_ok),
        .pump_en   (fl_pump_en),
        .fl_addr   (fl_addr),
        .fl_wdata  (fl_wdata),
        .prog_stb  (fl_prog_stb),
        .erase_stb (fl_erase_stb),
        .erase_all (fl_erase_all),
        .fl_raddr  (fl_raddr)
    );

    // R6: an accepted array write requires a configured divider
    a_r6_latch_needs_div: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !div_set && !stat_accerr && arr_wr && !reg_wr) |=> stat_accerr);

endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam int NOP   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic [7:0]    reg_wdata = '0;
    logic          arr_wr = 1'b0;
    logic [AW-1:0] arr_addr = '0;
    logic [7:0]    arr_wdata = '0;
    logic [7:0]    fl_rdata;
    logic          stat_bufempty, stat_done, stat_accerr, stat_blank_ok;
    logic [AW-1:0] fl_addr, fl_raddr;
    logic [7:0]    fl_wdata;
    logic          fl_prog_stb, fl_erase_stb, fl_erase_all, fl_pump_en;

    logic [7:0] mem [DEPTH];
    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW), .OP_CYCLES(NOP)) u_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .arr_wr(arr_wr), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .fl_rdata(fl_rdata),
        .stat_bufempty(stat_bufempty), .stat_done(stat_done),
        .stat_accerr(stat_accerr), .stat_blank_ok(stat_blank_ok),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_prog_stb(fl_prog_stb),
        .fl_erase_stb(fl_erase_stb), .fl_erase_all(fl_erase_all),
        .fl_raddr(fl_raddr), .fl_pump_en(fl_pump_en)
    );

    // behavioural array: program clears bits only, erase sets a page or all to 0xFF
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (fl_prog_stb) begin
            mem[fl_addr] <= mem[fl_addr] & fl_wdata;
        end else if (fl_erase_stb) begin
            for (int i = 0; i < DEPTH; i++)
                if (fl_erase_all || (i / 512) == (int'(fl_addr) / 512)) mem[i] <= 8'hFF;
        end
    end
    assign fl_rdata = mem[fl_raddr];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        check(act == exp, req, what, act, exp);
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [7:0] val);
        reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic arr_write(input int addr, input logic [7:0] val);
        arr_addr = AW'(addr); arr_wdata = val; arr_wr = 1'b1;
        @(negedge clk);
        arr_wr = 1'b0;
    endtask

    task automatic clear_err();
        reg_write(2'd2, 8'h20);
    endtask

    task automatic run_op(input int addr, input logic [7:0] val, input logic [7:0] code);
        arr_write(addr, val);
        reg_write(2'd1, code);
        reg_write(2'd2, 8'h80);
    endtask

    task automatic t_reset();
        chk("R1", "bufempty", int'(stat_bufempty), 1);
        chk("R1", "done", int'(stat_done), 1);
        chk("R1", "accerr", int'(stat_accerr), 0);
        chk("R1", "blank_ok", int'(stat_blank_ok), 0);
        chk("R1", "pump", int'(fl_pump_en), 0);
        chk("R1", "strobes", int'({fl_prog_stb, fl_erase_stb}), 0);
    endtask

    task automatic t_no_divider();
        arr_write(16, 8'h00);
        chk("R6", "accerr before divider", int'(stat_accerr), 1);
        reg_write(2'd1, 8'h20);
        reg_write(2'd2, 8'h80);
        idle(NOP + 1);
        chk("R6", "mem[16] untouched", int'(mem[16]), 8'hFF);
        clear_err();
        chk("R10", "accerr cleared", int'(stat_accerr), 0);
        reg_write(2'd0, 8'h13);
    endtask

    task automatic t_program();
        run_op(12'h123, 8'h5A, 8'h20);
        chk("R3", "prog strobe", int'(fl_prog_stb), 1);
        chk("R3", "strobe addr", int'(fl_addr), 12'h123);
        chk("R3", "strobe data", int'(fl_wdata), 8'h5A);
        chk("R2", "bufempty busy", int'(stat_bufempty), 0);
        chk("R2", "done busy", int'(stat_done), 0);
        chk("R3", "pump busy", int'(fl_pump_en), 1);
        idle(1);
        chk("R3", "strobe one cycle", int'(fl_prog_stb), 0);
        idle(NOP - 2);
        chk("R2", "bufempty last busy cycle", int'(stat_bufempty), 0);
        chk("R3", "pump last busy cycle", int'(fl_pump_en), 1);
        idle(1);
        chk("R2", "bufempty after run", int'(stat_bufempty), 1);
        chk("R2", "done after run", int'(stat_done), 1);
        chk("R3", "pump off after run", int'(fl_pump_en), 0);
        chk("R3", "mem programmed", int'(mem[12'h123]), 8'h5A);
    endtask

    task automatic t_erase();
        run_op(12'h300, 8'h00, 8'h20);
        idle(NOP);
        chk("R4", "setup program", int'(mem[12'h300]), 0);
        run_op(12'h2A7, 8'h00, 8'h40);
        chk("R4", "erase strobe", int'(fl_erase_stb), 1);
        chk("R4", "page aligned addr", int'(fl_addr), 12'h200);
        chk("R4", "erase_all low", int'(fl_erase_all), 0);
        idle(NOP);
        chk("R4", "page erased", int'(mem[12'h300]), 8'hFF);
        chk("R4", "other page kept", int'(mem[12'h123]), 8'h5A);
    endtask

    task automatic t_blank();
        run_op(0, 8'h00, 8'h05);
        chk("R5", "no strobe in scan", int'({fl_prog_stb, fl_erase_stb}), 0);
        idle(DEPTH - 1);
        chk("R5", "busy through scan", int'(stat_bufempty), 0);
        idle(1);
        chk("R5", "ready after scan", int'(stat_bufempty), 1);
        chk("R5", "not blank", int'(stat_blank_ok), 0);
        run_op(12'h3FF, 8'h00, 8'h41);
        chk("R4", "mass erase flag", int'(fl_erase_all), 1);
        idle(NOP);
        chk("R4", "mass erased", int'(mem[12'h123]), 8'hFF);
        run_op(12'h155, 8'h00, 8'h05);
        idle(DEPTH);
        chk("R5", "blank after mass erase", int'(stat_blank_ok), 1);
        chk("R5", "done after scan", int'(stat_done), 1);
    endtask

    task automatic t_busy_write();
        run_op(12'h150, 8'h3C, 8'h20);
        idle(2);
        arr_write(12'h151, 8'h00);
        chk("R7", "accerr on busy write", int'(stat_accerr), 1);
        idle(NOP - 4);
        chk("R7", "still busy", int'(stat_bufempty), 0);
        idle(1);
        chk("R7", "completes on time", int'(stat_bufempty), 1);
        chk("R7", "original data", int'(mem[12'h150]), 8'h3C);
        chk("R7", "second write dropped", int'(mem[12'h151]), 8'hFF);
        clear_err();
    endtask

    task automatic t_seq_errors();
        reg_write(2'd1, 8'h20);
        chk("R8", "cmd without address", int'(stat_accerr), 1);
        clear_err();
        arr_write(12'h160, 8'h01);
        reg_write(2'd1, 8'h20);
        reg_write(2'd1, 8'h20);
        chk("R8", "second command", int'(stat_accerr), 1);
        clear_err();
        reg_write(2'd2, 8'h80);
        chk("R8", "sequence discarded", int'(stat_accerr), 1);
        chk("R8", "no start", int'(stat_bufempty), 1);
        clear_err();
        arr_write(12'h161, 8'h01);
        reg_write(2'd1, 8'h77);
        chk("R8", "unknown code", int'(stat_accerr), 1);
        clear_err();
        idle(NOP);
        chk("R8", "array unchanged", int'(mem[12'h160]), 8'hFF);
        run_op(12'h162, 8'h0F, 8'h20);
        reg_write(2'd2, 8'h80);
        chk("R8", "start while busy ignored", int'(stat_accerr), 0);
        idle(NOP - 2);
        chk("R8", "run length unchanged", int'(stat_bufempty), 0);
        idle(1);
        chk("R8", "run ends", int'(stat_bufempty), 1);
    endtask

    task automatic t_abort();
        arr_write(12'h170, 8'h00);
        reg_write(2'd1, 8'h20);
        reg_write(2'd2, 8'h00);
        chk("R9", "abort error", int'(stat_accerr), 1);
        chk("R9", "no run", int'(stat_bufempty), 1);
        chk("R9", "no strobe", int'(fl_prog_stb), 0);
        idle(NOP + 1);
        chk("R9", "array unchanged", int'(mem[12'h170]), 8'hFF);
        clear_err();
    endtask

    task automatic t_sticky();
        reg_write(2'd1, 8'h20);
        arr_write(12'h180, 8'h00);
        reg_write(2'd1, 8'h20);
        reg_write(2'd2, 8'h80);
        chk("R10", "no start under error", int'(stat_bufempty), 1);
        chk("R10", "flag sticky", int'(stat_accerr), 1);
        reg_write(2'd2, 8'h80);
        chk("R10", "bit5 clear needed", int'(stat_accerr), 1);
        idle(NOP);
        chk("R10", "array unchanged", int'(mem[12'h180]), 8'hFF);
        clear_err();
        chk("R10", "w1c clears", int'(stat_accerr), 0);
    endtask

    task automatic t_burst();
        run_op(12'h040, 8'h11, 8'h25);
        idle(NOP);
        chk("R11", "pump held after byte", int'(fl_pump_en), 1);
        chk("R11", "ready after byte", int'(stat_bufempty), 1);
        arr_write(12'h041, 8'h22);
        chk("R11", "pump held same row", int'(fl_pump_en), 1);
        reg_write(2'd1, 8'h25);
        reg_write(2'd2, 8'h80);
        idle(NOP);
        chk("R11", "pump held second byte", int'(fl_pump_en), 1);
        chk("R11", "burst byte written", int'(mem[12'h041]), 8'h22);
        arr_write(12'h080, 8'h33);
        chk("R11", "pump off new row", int'(fl_pump_en), 0);
        reg_write(2'd1, 8'h20);
        reg_write(2'd2, 8'h80);
        idle(NOP);
        run_op(12'h0C0, 8'h44, 8'h25);
        idle(NOP);
        arr_write(12'h0C1, 8'h55);
        reg_write(2'd1, 8'h20);
        chk("R11", "pump off plain cmd", int'(fl_pump_en), 0);
        reg_write(2'd2, 8'h80);
        idle(NOP);
        run_op(12'h0C2, 8'h66, 8'h25);
        idle(NOP);
        arr_write(12'h0C3, 8'h77);
        reg_write(2'd2, 8'h00);
        chk("R11", "pump off on error", int'(fl_pump_en), 0);
        clear_err();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WDG", "watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_no_divider();
        t_program();
        t_erase();
        t_blank();
        t_busy_write();
        t_seq_errors();
        t_abort();
        t_sticky();
        t_burst();
        report();
        $finish;
    end

endmodule